// File: doc/BRIEF.md
# Mode-Controlled Significand Rounder

This block reduces a 64-bit significand to a narrower precision chosen at run time, using one of four rounding modes. Each input word comes with the sign of the value, a guard bit and a sticky bit from the preceding arithmetic. The block returns the rounded significand with every bit below the chosen precision cleared. It also returns three flags: an increment-carried-out flag that tells the exponent stage to add one, an inexact flag, and a flag that reports whether the magnitude was incremented.

The block sits after an adder, multiplier or divider datapath and before exponent adjustment. All outputs are registered. A result appears one clock after its inputs are presented, and a new input can be accepted every cycle. Exponent range checks, narrowing to a smaller storage format, and exception handling are left to other stages.

Top module: `sig_rounder`

## Requirements
- R1: With rmode_i = 2'b00 (nearest), the kept part is incremented when the discarded part is more than half a unit in the last kept place, and left unchanged when it is less than half.
- R2: In nearest mode, when the discarded part is exactly half a unit, the result is the neighbour whose last kept bit is 0. An odd kept part is incremented and an even one is not.
- R3: With rmode_i = 2'b01 (toward minus infinity), the magnitude is incremented exactly when sign_i = 1 and the result is inexact.
- R4: With rmode_i = 2'b10 (toward plus infinity), the magnitude is incremented exactly when sign_i = 0 and the result is inexact.
- R5: With rmode_i = 2'b11 (truncate), all discarded bits are dropped and the magnitude is never incremented.
- R6: prec_i = 2'b00 keeps the top 24 bits (sig_o[39:0] cleared), 2'b10 keeps the top 53 bits (sig_o[10:0] cleared), and 2'b11 keeps all 64 bits. In the 64-bit case, guard_i sits just below bit 0.
- R7: The reserved code prec_i = 2'b01 behaves exactly like 2'b11 (64 bits kept).
- R8: inexact_o is 1 exactly when any discarded bit is nonzero. The discarded bits are the significand bits below the kept precision, guard_i and sticky_i.
- R9: round_up_o is 1 exactly when the kept magnitude was incremented.
- R10: When incrementing a kept part of all ones carries out of the precision, sig_o = 64'h8000_0000_0000_0000 and exp_inc_o = 1. Otherwise exp_inc_o = 0.
- R11: Results appear on the outputs at the first rising clock edge after the inputs are presented. While rst_ni is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sign_i | input | 1 | Sign of the value being rounded (1 = negative) |
| sig_i | input | 64 | Significand, MSB first |
| guard_i | input | 1 | Bit just below sig_i[0] |
| sticky_i | input | 1 | OR of all bits below the guard bit |
| rmode_i | input | 2 | Rounding mode: 00 nearest-even, 01 toward -inf, 10 toward +inf, 11 truncate |
| prec_i | input | 2 | Precision: 00 24 bits, 01 reserved (as 64), 10 53 bits, 11 64 bits |
| sig_o | output | 64 | Rounded significand, bits below precision cleared |
| exp_inc_o | output | 1 | Rounding carried out of the significand; exponent must add one |
| inexact_o | output | 1 | Some discarded bit was nonzero |
| round_up_o | output | 1 | Magnitude was incremented |

## Verification
Every output is produced by a single register stage. The result for a set of inputs is therefore due at the first rising edge after those inputs are applied. The bench changes inputs on the falling edge, lets one rising edge pass, and compares all four outputs on the next falling edge. At that point each output has settled and no new input has been applied yet. The clocked properties use the same one-cycle offset and relate the current outputs to the inputs and masks of the previous cycle.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  typedef enum logic [1:0] {
    RM_NEAR  = 2'b00,
    RM_DOWN  = 2'b01,
    RM_UP    = 2'b10,
    RM_TRUNC = 2'b11
  } rmode_e;

  typedef enum logic [1:0] {
    PC_SHORT = 2'b00,
    PC_RSVD  = 2'b01,
    PC_MID   = 2'b10,
    PC_FULL  = 2'b11
  } prec_e;
endpackage

// File: rtl/rnd_mask.sv
module rnd_mask #(
  parameter int W          = 64,
  parameter int SHORT_BITS = 24,
  parameter int MID_BITS   = 53
) (
  input  logic [1:0]   prec_i,
  output logic [W-1:0] drop_mask_o,
  output logic [W-1:0] unit_o
);
  import rnd_pkg::*;
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] DROP_SHORT = CW'(W - SHORT_BITS);
  localparam logic [CW-1:0] DROP_MID   = CW'(W - MID_BITS);

  logic [CW-1:0] drop_cnt;

  always_comb begin
    unique case (prec_e'(prec_i))
      PC_SHORT: drop_cnt = DROP_SHORT;
      PC_MID:   drop_cnt = DROP_MID;
      default:  drop_cnt = '0;  // full and reserved code
    endcase
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign drop_mask_o[i] = (CW'(i) < drop_cnt);
    assign unit_o[i]      = (CW'(i) == drop_cnt);
  end
endmodule

// File: rtl/rnd_decide.sv
module rnd_decide (
  input  logic       sign_i,
  input  logic [1:0] rmode_i,
  input  logic       lsb_i,
  input  logic       guard_i,
  input  logic       sticky_i,
  output logic       inc_o,
  output logic       inexact_o
);
  import rnd_pkg::*;

  assign inexact_o = guard_i | sticky_i;

  always_comb begin
    unique case (rmode_e'(rmode_i))
      RM_NEAR:  inc_o = guard_i & (sticky_i | lsb_i);
      RM_DOWN:  inc_o = sign_i & inexact_o;
      RM_UP:    inc_o = ~sign_i & inexact_o;
      default:  inc_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/sig_rounder.sv
module sig_rounder #(
  parameter int W          = 64,
  parameter int SHORT_BITS = 24,
  parameter int MID_BITS   = 53
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sign_i,
  input  logic [W-1:0] sig_i,
  input  logic         guard_i,
  input  logic         sticky_i,
  input  logic [1:0]   rmode_i,
  input  logic [1:0]   prec_i,
  output logic [W-1:0] sig_o,
  output logic         exp_inc_o,
  output logic         inexact_o,
  output logic         round_up_o
);
  import rnd_pkg::*;
  localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] drop_mask, unit, half_bit, below_half, kept;
  logic         lsb, g_eff, s_eff, inc, inexact, carry;
  logic [W-1:0] sum, rounded;

  rnd_mask #(.W(W), .SHORT_BITS(SHORT_BITS), .MID_BITS(MID_BITS)) u_mask (
    .prec_i      (prec_i),
    .drop_mask_o (drop_mask),
    .unit_o      (unit)
  );

  // guard moves up into the significand when bits are dropped
  assign half_bit   = unit >> 1;
  assign below_half = drop_mask & ~half_bit;
  assign lsb        = |(sig_i & unit);
  assign g_eff      = |(sig_i & half_bit) | (unit[0] & guard_i);
  assign s_eff      = |(sig_i & below_half) | sticky_i | (guard_i & ~unit[0]);

  rnd_decide u_dec (
    .sign_i    (sign_i),
    .rmode_i   (rmode_i),
    .lsb_i     (lsb),
    .guard_i   (g_eff),
    .sticky_i  (s_eff),
    .inc_o     (inc),
    .inexact_o (inexact)
  );

  assign kept           = sig_i & ~drop_mask;
  assign {carry, sum}   = {1'b0, kept} + {1'b0, (inc ? unit : '0)};
  assign rounded        = carry ? MSB_ONLY : sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sig_o      <= '0;
      exp_inc_o  <= 1'b0;
      inexact_o  <= 1'b0;
      round_up_o <= 1'b0;
    end else begin
      sig_o      <= rounded;
      exp_inc_o  <= carry;
      inexact_o  <= inexact;
      round_up_o <= inc;
    end
  end

  p_low_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sig_o & $past(drop_mask)) == '0));
  p_trunc_no_inc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rmode_i == RM_TRUNC) |=> !round_up_o);
  p_down_pos_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rmode_i == RM_DOWN && !sign_i) |=> !round_up_o);
  p_up_neg_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rmode_i == RM_UP && sign_i) |=> !round_up_o);
  p_up_inexact_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    round_up_o |-> inexact_o);
  p_carry_msb_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_inc_o |-> (round_up_o && sig_o == MSB_ONLY));
  p_exact_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!guard_i && !sticky_i && (sig_i & drop_mask) == '0) |=> (!inexact_o && sig_o == $past(sig_i)));
endmodule

// File: tb/tb_sig_rounder.sv
`timescale 1ns/1ps
module tb_sig_rounder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sign_i = 1'b0, guard_i = 1'b0, sticky_i = 1'b0;
  logic [63:0] sig_i = '0;
  logic [1:0]  rmode_i = '0, prec_i = '0;
  logic [63:0] sig_o;
  logic        exp_inc_o, inexact_o, round_up_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sig_rounder dut (
    .clk_i(clk), .rst_ni(rst_n), .sign_i(sign_i), .sig_i(sig_i),
    .guard_i(guard_i), .sticky_i(sticky_i), .rmode_i(rmode_i), .prec_i(prec_i),
    .sig_o(sig_o), .exp_inc_o(exp_inc_o), .inexact_o(inexact_o), .round_up_o(round_up_o)
  );

  // returns {exp_inc, inexact, round_up, sig}
  function automatic logic [66:0] ref_round(input logic s, input logic [63:0] m,
      input logic g, input logic st, input logic [1:0] rm, input logic [1:0] pc);
    int drop;
    logic [65:0] ext, rem, half;
    logic [63:0] q, res;
    logic [64:0] q1;
    logic gt, eq, nz, up, ovf;
    drop = (pc == 2'b00) ? 40 : (pc == 2'b10) ? 11 : 0;
    ext  = {1'b0, m, g};
    rem  = ext & ((66'd1 << (drop + 1)) - 66'd1);
    half = 66'd1 << drop;
    q    = m >> drop;
    nz   = (rem != 0) || st;
    gt   = (rem > half) || (rem == half && st);
    eq   = (rem == half) && !st;
    case (rm)
      2'b00:   up = gt || (eq && q[0]);
      2'b01:   up = s && nz;
      2'b10:   up = !s && nz;
      default: up = 1'b0;
    endcase
    q1  = {1'b0, q} + 65'd1;
    ovf = up && (q1 == (65'd1 << (64 - drop)));
    if (ovf)     res = 64'h8000_0000_0000_0000;
    else if (up) res = q1[63:0] << drop;
    else         res = q << drop;
    return {ovf, nz, up, res};
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic s, input logic [63:0] m, input logic g, input logic st,
      input logic [1:0] rm, input logic [1:0] pc, input string req);
    logic [66:0] e;
    @(negedge clk);
    sign_i = s; sig_i = m; guard_i = g; sticky_i = st; rmode_i = rm; prec_i = pc;
    e = ref_round(s, m, g, st, rm, pc);
    @(posedge clk);
    @(negedge clk);
    chk(req, "sig R6", sig_o, e[63:0]);
    chk(req, "inexact R8", {63'd0, inexact_o}, {63'd0, e[65]});
    chk(req, "round_up R9", {63'd0, round_up_o}, {63'd0, e[64]});
    chk(req, "exp_inc R10", {63'd0, exp_inc_o}, {63'd0, e[66]});
  endtask

  initial begin : watchdog
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] m;
    logic [63:0] last;
    void'($urandom(32'd20240611));
    sig_i = 64'hFFFF_FFFF_FFFF_FFFF; guard_i = 1; sticky_i = 1;
    #10;
    // R11 reset state
    chk("R11", "reset sig", sig_o, 64'd0);
    chk("R11", "reset flags", {61'd0, exp_inc_o, inexact_o, round_up_o}, 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // R1 above/below half, 24-bit
    apply(0, 64'h0000_00C0_0000_0000, 0, 0, 2'b00, 2'b00, "R1");
    chk("R1", "above half up", sig_o, 64'h0000_0100_0000_0000);
    apply(0, 64'h0000_0040_0000_0000, 0, 0, 2'b00, 2'b00, "R1");
    chk("R1", "below half down", sig_o, 64'h0);
    // R2 ties to even at 53 and 64 bits
    apply(0, 64'h0000_0000_0000_0400, 0, 0, 2'b00, 2'b10, "R2");
    chk("R2", "tie even stays", sig_o, 64'h0);
    apply(0, 64'h0000_0000_0000_0C00, 0, 0, 2'b00, 2'b10, "R2");
    chk("R2", "tie odd rounds", sig_o, 64'h0000_0000_0000_1000);
    apply(0, 64'h0000_0000_0000_0003, 1, 0, 2'b00, 2'b11, "R2");
    chk("R2", "tie odd full", sig_o, 64'h4);
    // R3/R4 sign dependence
    apply(1, 64'h8000_0000_0000_0000, 0, 1, 2'b01, 2'b11, "R3");
    chk("R3", "neg down incs", {63'd0, round_up_o}, 64'd1);
    apply(0, 64'h8000_0000_0000_0000, 0, 1, 2'b01, 2'b11, "R3");
    chk("R3", "pos down holds", {63'd0, round_up_o}, 64'd0);
    apply(0, 64'h8000_0000_0000_0001, 0, 1, 2'b10, 2'b00, "R4");
    chk("R4", "pos up incs", sig_o, 64'h8000_0100_0000_0000);
    apply(1, 64'h8000_0000_0000_0001, 0, 1, 2'b10, 2'b00, "R4");
    chk("R4", "neg up holds", sig_o, 64'h8000_0000_0000_0000);
    // R5 truncate
    apply(0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 2'b11, 2'b00, "R5");
    chk("R5", "trunc drops", sig_o, 64'hFFFF_FF00_0000_0000);
    // R7 reserved precision acts as 64
    apply(0, 64'h1234_5678_9ABC_DEF1, 1, 1, 2'b00, 2'b01, "R7");
    chk("R7", "reserved keeps 64", sig_o, 64'h1234_5678_9ABC_DEF2);
    // R8 inexact from sticky only
    apply(0, 64'h8000_0000_0000_0000, 0, 1, 2'b11, 2'b10, "R8");
    chk("R8", "sticky only inexact", {63'd0, inexact_o}, 64'd1);
    // R10 carry out at each precision
    apply(0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 2'b00, 2'b11, "R10");
    chk("R10", "carry 64", {63'd0, exp_inc_o}, 64'd1);
    apply(1, 64'hFFFF_FF00_0000_0001, 0, 0, 2'b01, 2'b00, "R10");
    chk("R10", "carry 24", sig_o, 64'h8000_0000_0000_0000);
    apply(0, 64'hFFFF_FFFF_FFFF_F800, 0, 1, 2'b10, 2'b10, "R10");
    chk("R10", "carry 53", {63'd0, exp_inc_o}, 64'd1);

    // random with tie/carry bias
    for (int i = 0; i < 3000; i++) begin
      int sel;
      logic [1:0] pc;
      sel = $urandom % 6;
      m = {$urandom, $urandom};
      pc = 2'($urandom);
      if (sel == 0) m[39:0] = 40'h80_0000_0000;
      if (sel == 1) m[10:0] = 11'h400;
      if (sel == 2) m = 64'hFFFF_FFFF_FFFF_FFFF;
      apply(1'($urandom), m, (sel < 2) ? 1'b0 : 1'($urandom), (sel < 2) ? 1'b0 : 1'($urandom),
            2'($urandom), pc, "R1 R2 R3 R4 R5 R7");
    end

    // R11 one-cycle latency: output holds previous result until the edge
    apply(0, 64'h0F0F_0F0F_0F0F_0F0F, 0, 0, 2'b11, 2'b11, "R11");
    last = sig_o;
    sig_i = 64'h1111_1111_1111_1111;
    #1;
    chk("R11", "no change before edge", sig_o, last);
    @(posedge clk); @(negedge clk);
    chk("R11", "new result after edge", sig_o, 64'h1111_1111_1111_1111);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule